// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit single-precision binary floating-point words. It has one register stage. A control input selects subtraction. The block first compares the two biased exponents. It steers the operand with the larger exponent onto the "big" path and shifts the significand of the other operand right by the exponent gap. Guard, round and sticky bits are kept during that shift. A small control network looks at both operand signs and the subtract select, and decides whether the aligned significands are added or subtracted in magnitude.

After the significand add or subtract, the sum is normalized by one right shift or by a leading-zero left shift. The exponent is adjusted to match. The result is then rounded to nearest, with ties going to even. NaN, infinity and zero operands go through a special-case path. Denormal operands are flagged and read as signed zeros. Results too small to be normal are flushed to signed zero.

The result and the three flags appear on the outputs one clock edge after the operands are applied.

Top module: `sp_addsub`

## Requirements
- R1: Words use sign at bit 31, biased exponent at bits 30:23 (bias 127) and fraction at bits 22:0. For normal or zero operands, `res` is the exact sum rounded to nearest with ties to even.
- R2: With `op_sub` high, the result equals `op_a` plus `op_b` with its sign bit inverted.
- R3: Result and flags are registered and appear one clock edge after the operands. While `rst` is high at an edge, all outputs become zero.
- R4: If either operand has exponent 255 and a nonzero fraction, `res` is 0x7FC00000 and `flag_invalid` stays low.
- R5: If both operands are infinities whose effective signs differ, `res` is 0x7FC00000 and `flag_invalid` is high.
- R6: Any other case with an infinite operand returns that infinity, carrying its effective sign.
- R7: If the rounded exponent would reach 255, `res` is the signed infinity (exponent 255, fraction 0) and `flag_ovf` is high.
- R8: A zero-magnitude sum is +0. The exception is when both effective signs are negative; that case gives -0 (0x80000000).
- R9: An operand with exponent 0 and nonzero fraction sets `flag_denorm`. It is then used as a zero with its own sign.
- R10: A nonzero result below 2^-126 in magnitude is returned as a zero with the sign of the result.
- R11: An exactly halfway result rounds to the neighbour whose fraction LSB is 0.
- R12: When the exponent gap exceeds the significand width, the smaller operand affects the result only through the sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects a minus b, 0 selects a plus b |
| res | output | 32 | Registered result word |
| flag_invalid | output | 1 | Infinity minus infinity occurred |
| flag_ovf | output | 1 | Result overflowed to infinity |
| flag_denorm | output | 1 | An operand was denormal |

## Verification
The checker relates each output to the operands of the previous cycle. It compares them only after one clean edge out of reset, so it assumes operands are meaningful in every cycle and are not qualified by any valid signal. The random stimulus keeps operand exponents in the normal range, and half the pairs have nearby exponents so that cancellation and rounding paths are exercised. NaN, infinity, denormal, overflow and flush cases are applied as directed vectors. Expected results come from a bench model built on double-precision arithmetic with its own rounding.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;          // significand + guard, round, sticky
    localparam int LZ_W   = $clog2(EXT_W + 1);
    localparam int EW     = EXP_W + 2;          // signed working exponent width
    localparam logic [EXP_W-1:0]  EXP_ALL1 = '1;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              nan;
        logic              inf;
        logic              den;
    } fp_op_t;

    typedef struct packed {
        logic eff_sub;
        logic sign_b;
    } ctl_t;

    // Decide the effective operation from both signs and the select.
    function automatic ctl_t op_control(input logic sa, input logic sb, input logic sub);
        ctl_t c;
        c.sign_b  = sb ^ sub;
        c.eff_sub = sa ^ c.sign_b;
        return c;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
    import fpa_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              sign_eff,
    output fp_op_t            op
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    always_comb begin
        e        = word[WORD_W-2 -: EXP_W];
        f        = word[FRAC_W-1:0];
        op.sign  = sign_eff;
        op.nan   = (e == EXP_ALL1) && (f != '0);
        op.inf   = (e == EXP_ALL1) && (f == '0);
        op.den   = (e == '0) && (f != '0);
        op.exp   = e;
        // denormals are read as zero; zero has no hidden bit
        op.sig   = (e == '0) ? '0 : {1'b1, f};
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
(
    input  fp_op_t           op_a,
    input  fp_op_t           op_b,
    output fp_op_t           big,
    output logic             small_sign,
    output logic [EXT_W-1:0] small_al
);
    logic [EXP_W:0]   diff;
    logic [EXP_W:0]   gap;
    logic             swap;
    fp_op_t           sml;
    logic [EXT_W-1:0] v;
    logic             lost;

    always_comb begin
        diff       = {1'b0, op_a.exp} - {1'b0, op_b.exp};
        swap       = diff[EXP_W];
        gap        = swap ? (~diff + 1'b1) : diff;
        big        = swap ? op_b : op_a;
        sml        = swap ? op_a : op_b;
        small_sign = sml.sign;
        v          = {sml.sig, 3'b000};
        if (gap >= (EXP_W+1)'(EXT_W)) begin
            small_al = {{(EXT_W-1){1'b0}}, |v};
            lost     = 1'b0;
        end else begin
            small_al = v >> gap;
            lost     = |(v & ~({EXT_W{1'b1}} << gap));
        end
        small_al[0] = small_al[0] | lost;
    end
endmodule

// File: rtl/fpa_normround.sv
module fpa_normround
    import fpa_pkg::*;
(
    input  fp_op_t            big,
    input  logic              small_sign,
    input  logic [EXT_W-1:0]  small_al,
    input  logic              eff_sub,
    output logic [WORD_W-1:0] word,
    output logic              ovf
);
    logic [EXT_W-1:0]  bx;
    logic [EXT_W:0]    sum;
    logic              sgn;
    logic [EXT_W-1:0]  n;
    logic [EW-1:0]     e;
    logic [LZ_W-1:0]   lz;
    logic              up;
    logic [SIG_W:0]    mr;

    always_comb begin
        bx  = {big.sig, 3'b000};
        sgn = big.sign;
        lz  = '0;
        if (!eff_sub) begin
            sum = {1'b0, bx} + {1'b0, small_al};
        end else if (bx >= small_al) begin
            sum = {1'b0, bx} - {1'b0, small_al};
        end else begin
            sum = {1'b0, small_al} - {1'b0, bx};
            sgn = ~big.sign;
        end

        if (sum[EXT_W]) begin
            n = sum[EXT_W:1];
            n[0] = n[0] | sum[0];
            e = {2'b00, big.exp} + 1'b1;
        end else begin
            lz = lead_zeros(sum[EXT_W-1:0]);
            n  = sum[EXT_W-1:0] << lz;
            e  = {2'b00, big.exp} - {{(EW-LZ_W){1'b0}}, lz};
        end

        up = n[2] & (n[1] | n[0] | n[3]);
        mr = {1'b0, n[EXT_W-1:3]} + {{SIG_W{1'b0}}, up};
        if (mr[SIG_W]) e = e + 1'b1;

        ovf  = 1'b0;
        if (sum == '0) begin
            word = {big.sign & small_sign, {(WORD_W-1){1'b0}}};
        end else if (e[EW-1] || e == '0) begin
            word = {sgn, {(WORD_W-1){1'b0}}};
        end else if (e >= {2'b00, EXP_ALL1}) begin
            word = {sgn, EXP_ALL1, {FRAC_W{1'b0}}};
            ovf  = 1'b1;
        end else begin
            word = {sgn, e[EXP_W-1:0], mr[SIG_W] ? {FRAC_W{1'b0}} : mr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/sp_addsub.sv
module sp_addsub
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output logic [WORD_W-1:0] res,
    output logic              flag_invalid,
    output logic              flag_ovf,
    output logic              flag_denorm
);
    ctl_t              ctl;
    fp_op_t            ua, ub, big;
    logic              small_sign;
    logic [EXT_W-1:0]  small_al;
    logic [WORD_W-1:0] arith_word;
    logic              arith_ovf;
    logic [WORD_W-1:0] nxt_res;
    logic              nxt_inv, nxt_ovf;

    assign ctl = op_control(op_a[WORD_W-1], op_b[WORD_W-1], op_sub);

    fpa_unpack u_unp_a (.word(op_a), .sign_eff(op_a[WORD_W-1]), .op(ua));
    fpa_unpack u_unp_b (.word(op_b), .sign_eff(ctl.sign_b),     .op(ub));

    fpa_align u_align (
        .op_a(ua), .op_b(ub), .big(big),
        .small_sign(small_sign), .small_al(small_al)
    );

    fpa_normround u_norm (
        .big(big), .small_sign(small_sign), .small_al(small_al),
        .eff_sub(ctl.eff_sub), .word(arith_word), .ovf(arith_ovf)
    );

    always_comb begin
        nxt_inv = 1'b0;
        nxt_ovf = 1'b0;
        if (ua.nan || ub.nan) begin
            nxt_res = QNAN;
        end else if (ua.inf && ub.inf && ctl.eff_sub) begin
            nxt_res = QNAN;
            nxt_inv = 1'b1;
        end else if (ua.inf) begin
            nxt_res = {ua.sign, EXP_ALL1, {FRAC_W{1'b0}}};
        end else if (ub.inf) begin
            nxt_res = {ub.sign, EXP_ALL1, {FRAC_W{1'b0}}};
        end else begin
            nxt_res = arith_word;
            nxt_ovf = arith_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res          <= '0;
            flag_invalid <= 1'b0;
            flag_ovf     <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            res          <= nxt_res;
            flag_invalid <= nxt_inv;
            flag_ovf     <= nxt_ovf;
            flag_denorm  <= ua.den | ub.den;
        end
    end
endmodule

// File: rtl/sp_addsub_chk.sv
module sp_addsub_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [31:0] res,
    input logic        flag_invalid,
    input logic        flag_ovf,
    input logic        flag_denorm
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    assert_nan_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past((op_a[30:23] == 8'hFF && op_a[22:0] != 0) ||
                         (op_b[30:23] == 8'hFF && op_b[22:0] != 0))
        |-> (res == 32'h7FC00000 && !flag_invalid));

    assert_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> (res == 32'h7FC00000 && !flag_ovf));

    assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        flag_ovf |-> (res[30:0] == 31'h7F800000));

    assert_denflag_R9: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past((op_a[30:23] == 8'h00 && op_a[22:0] != 0) ||
                         (op_b[30:23] == 8'h00 && op_b[22:0] != 0))
        |-> flag_denorm);

    assert_stable_R3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $stable(op_a) && $stable(op_b) && $past(past_ok) |=> $stable(res));
endmodule

bind sp_addsub sp_addsub_chk u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .res(res),
    .flag_invalid(flag_invalid), .flag_ovf(flag_ovf), .flag_denorm(flag_denorm)
);

// File: tb/sp_addsub_tb.sv
module sp_addsub_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        op_sub;
    logic [31:0] res;
    logic        flag_invalid, flag_ovf, flag_denorm;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    sp_addsub u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .res(res), .flag_invalid(flag_invalid), .flag_ovf(flag_ovf),
        .flag_denorm(flag_denorm)
    );

    function automatic logic is_den(input logic [31:0] x);
        return x[30:23] == 8'h00 && x[22:0] != 0;
    endfunction

    function automatic real to_real(input logic [31:0] x);
        logic [10:0] e;
        if (x[30:23] == 8'h00) return $bitstoreal({x[31], 63'b0});
        e = {3'b000, x[30:23]} + 11'd896;
        return $bitstoreal({x[31], e, x[22:0], 29'b0});
    endfunction

    // reference: round a double to single, nearest-even, flush tiny to zero
    function automatic logic [32:0] to_single(input real r);
        logic [63:0] d;
        int          ue;
        logic [24:0] m;
        logic        up;
        d = $realtobits(r);
        if (d[62:52] == 0) return {1'b0, d[63], 31'b0};
        ue = int'(d[62:52]) - 1023;
        if (ue < -126) return {1'b0, d[63], 31'b0};
        up = d[28] & ((|d[27:0]) | d[29]);
        m  = {2'b01, d[51:29]} + {24'b0, up};
        if (m[24]) ue = ue + 1;
        if (ue > 127) return {1'b1, d[63], 8'hFF, 23'b0};
        return {1'b0, d[63], 8'(ue + 127), m[24] ? 23'b0 : m[22:0]};
    endfunction

    // returns {invalid, ovf, denorm, result}
    function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic [31:0] bb, fa, fb;
        logic        den, an, bn, ai, bi;
        logic [32:0] r;
        bb  = {b[31] ^ s, b[30:0]};
        den = is_den(a) | is_den(b);
        an  = a[30:23] == 8'hFF && a[22:0] != 0;
        bn  = b[30:23] == 8'hFF && b[22:0] != 0;
        ai  = a[30:23] == 8'hFF && a[22:0] == 0;
        bi  = b[30:23] == 8'hFF && b[22:0] == 0;
        if (an || bn) return {2'b00, den, 32'h7FC00000};
        if (ai && bi && (a[31] != bb[31])) return {2'b10, den, 32'h7FC00000};
        if (ai) return {2'b00, den, a[31], 8'hFF, 23'b0};
        if (bi) return {2'b00, den, bb[31], 8'hFF, 23'b0};
        fa = is_den(a) ? {a[31], 31'b0} : a;
        fb = is_den(bb) ? {bb[31], 31'b0} : bb;
        r  = to_single(to_real(fa) + to_real(fb));
        return {1'b0, r[32], den, r[31:0]};
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
        logic [34:0] exp_v;
        @(negedge clk);
        op_a = a; op_b = b; op_sub = s;
        exp_v = model(a, b, s);
        @(posedge clk);
        #2;
        total++;
        if ({flag_invalid, flag_ovf, flag_denorm, res} !== exp_v) begin
            bad++;
            $display("FAIL %s: a=%h b=%h sub=%0b got res=%h inv=%0b ovf=%0b den=%0b expected res=%h inv=%0b ovf=%0b den=%0b",
                     tag, a, b, s, res, flag_invalid, flag_ovf, flag_denorm,
                     exp_v[31:0], exp_v[34], exp_v[33], exp_v[32]);
        end
    endtask

    task automatic want(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic [31:0] w, input string tag);
        run(a, b, s, tag);
        total++;
        if (res !== w) begin
            bad++;
            $display("FAIL %s: fixed value got %h expected %h", tag, res, w);
        end
    endtask

    initial begin
        rst = 1'b1; op_a = 0; op_b = 0; op_sub = 0;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if ({res, flag_invalid, flag_ovf, flag_denorm} !== 35'b0) begin
            bad++;
            $display("FAIL R3: reset outputs got %h expected 0", res);
        end
        @(negedge clk); rst = 1'b0;

        want(32'h3F800000, 32'h3F800000, 0, 32'h40000000, "R1 1+1");
        want(32'h40400000, 32'h3F800000, 1, 32'h40000000, "R2 3-1");
        want(32'h3F800000, 32'hBF800000, 1, 32'h40000000, "R2 1-(-1)");
        want(32'h3F800000, 32'h3F800000, 1, 32'h00000000, "R8 cancel");
        want(32'h80000000, 32'h80000000, 0, 32'h80000000, "R8 neg zeros");
        want(32'h7FC12345, 32'h3F800000, 0, 32'h7FC00000, "R4 nan");
        want(32'h7F800000, 32'h7F800000, 1, 32'h7FC00000, "R5 inf-inf");
        want(32'hFF800000, 32'h7F800000, 0, 32'h7FC00000, "R5 -inf+inf");
        want(32'h3F800000, 32'h7F800000, 1, 32'hFF800000, "R6 1-inf");
        want(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 32'h7F800000, "R7 overflow");
        want(32'h00000001, 32'h3F800000, 0, 32'h3F800000, "R9 denorm");
        want(32'h00800001, 32'h00800000, 1, 32'h00000000, "R10 flush");
        want(32'h3F800000, 32'h33800000, 0, 32'h3F800000, "R11 tie down");
        want(32'h3F800001, 32'h33800000, 0, 32'h3F800002, "R11 tie up");
        want(32'h3F800000, 32'h0DA24260, 0, 32'h3F800000, "R12 far");
        want(32'h3F800000, 32'h33000001, 1, 32'h3F7FFFFF, "R12 sticky");

        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ea, eb;
            logic [31:0] a, b;
            ea = 8'd1 + 8'($urandom % 254);
            if (i % 2 == 0) begin
                int t;
                t  = int'(ea) + int'($urandom % 7) - 3;
                if (t < 1) t = 1;
                if (t > 254) t = 254;
                eb = 8'(t);
            end else begin
                eb = 8'd1 + 8'($urandom % 254);
            end
            a = {1'($urandom), ea, 23'($urandom)};
            b = {1'($urandom), eb, 23'($urandom)};
            run(a, b, 1'($urandom), "R1 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule